// File: doc/BRIEF.md
# Multi-Slope Integrating Converter Sequencer

This block is the digital sequencer for an integrating analog-to-digital converter. It runs one conversion as a fixed order of phases: auto-zero, a fixed-length integration of the input, a fast deintegration with a heavy reference, and a slow deintegration with a reference of the opposite sign and a weight 2^SLOW_BITS smaller. It drives one select line per analog switch group and one reference-sign select. Its only analog feedback is a single comparator bit that reports whether the integrator sits above zero.

The fast phase brings the integrator past zero in coarse steps. The slow phase then walks it back in fine steps until it crosses zero again. The magnitude is the fast cycle count scaled by 2^SLOW_BITS minus the slow cycle count. This removes most of the long single ramp a plain dual-slope scheme needs. With the default parameters the result has 15 magnitude bits plus a sign bit and an overrange flag.

Conversions start on a one-cycle start pulse or run back to back in continuous mode. A busy flag covers each conversion.

Top module: `islope_seq`

## Requirements
- R1: While the synchronous active-high reset is applied, and after it is released, the block is idle: busy, every select, ref_negative, result, result_neg and overrange are all 0.
- R2: With cont_mode low, a start pulse taken while idle makes busy and sel_autozero go high on the next cycle. sel_autozero stays high for exactly AZ_CYCLES cycles, then sel_integrate stays high for exactly INT_CYCLES cycles.
- R3: At most one of sel_autozero, sel_integrate, sel_ref_fast and sel_ref_slow is high in any cycle. None of them is high while busy is low.
- R4: The input sign is captured from the synchronized comparator in the last integrate cycle, where cmp_pos=1 means the integrator is above zero. During the fast phase ref_negative equals that captured bit. During the slow phase it is its inverse.
- R5: cmp_pos reaches the state machine through SYNC_STAGES (default 2) flops. The fast phase ends in the first cycle whose synchronized comparator differs from the captured sign, and that cycle is counted as a fast cycle.
- R6: The slow phase ends in the first cycle whose synchronized comparator equals the captured sign again, and that cycle is counted. The slow phase also ends if it reaches 2^(SLOW_BITS+2) cycles.
- R7: At the end of a conversion, result = fast_cycles*2^SLOW_BITS - slow_cycles, clamped to 0 when negative. result_neg is the inverse of the captured sign, so 1 means a negative or zero input.
- R8: If 2^FAST_BITS fast cycles pass without a comparator change, the conversion ends with no slow phase. overrange is then 1 and result is all ones (32767 by default).
- R9: result, result_neg and overrange change only on the clock edge where busy falls. They hold their values for the whole of a conversion.
- R10: With cont_mode high, busy stays low for exactly one cycle between conversions before the next one starts. After cont_mode is lowered while idle, no further conversion starts.
- R11: A start pulse that arrives while busy is ignored. The conversion in progress keeps its phase lengths, and no conversion follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| cont_mode | input | 1 | 1 = back-to-back conversions |
| start | input | 1 | One-cycle request for a single conversion |
| cmp_pos | input | 1 | Asynchronous comparator, 1 = integrator above zero |
| busy | output | 1 | Conversion in progress |
| sel_autozero | output | 1 | Offset-nulling switches closed |
| sel_integrate | output | 1 | Input connected to the integrator |
| sel_ref_fast | output | 1 | Heavy reference connected |
| sel_ref_slow | output | 1 | Light reference connected |
| ref_negative | output | 1 | 1 = negative reference selected |
| result | output | FAST_BITS+SLOW_BITS | Conversion magnitude |
| result_neg | output | 1 | Sign of the converted input |
| overrange | output | 1 | Fast phase ran out of range |

## Verification
The bench models the integrator cycle by cycle and targets these corner cases:
- Charges that are exact multiples of the fast step. An off-by-one in counting the exit cycle would shift every result by 64 or by 1.
- Inputs near zero. Without the clamp, a design would wrap the small negative difference into a huge magnitude.
- Charges on either side of the fast-phase limit, for both signs. A wrong limit compare would flag overrange one step early, or would let the fast counter wrap.
- A start pulse during a conversion. A design that did not gate start would queue an extra conversion or restart its phases.
- The one-cycle idle gap in continuous mode. Getting this wrong would either drop busy for more than one cycle or keep it high with no gap.

// File: rtl/islope_pkg.sv
`timescale 1ns/1ps
package islope_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_AZ,
        PH_INTEG,
        PH_FAST,
        PH_SLOW
    } phase_t;
endpackage

// File: rtl/islope_sync.sv
`timescale 1ns/1ps
module islope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], din};
    end

    assign dout = shreg[STAGES-1];
endmodule

// File: rtl/islope_result.sv
`timescale 1ns/1ps
module islope_result #(
    parameter int FAST_BITS = 9,
    parameter int SLOW_BITS = 6,
    parameter int SLOW_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           load,
    input  logic                           ovr_in,
    input  logic                           neg_in,
    input  logic [FAST_BITS:0]             fast_n,
    input  logic [SLOW_W:0]                slow_n,
    output logic [FAST_BITS+SLOW_BITS-1:0] mag,
    output logic                           neg,
    output logic                           ovr
);
    localparam int RW = FAST_BITS + SLOW_BITS;
    localparam int XW = RW + 3;

    logic [XW-1:0] up_w, dn_w, diff_w;
    logic          under, over;
    logic [RW-1:0] mag_nx;

    always_comb begin
        up_w   = XW'(fast_n) << SLOW_BITS;
        dn_w   = XW'(slow_n);
        under  = dn_w > up_w;
        diff_w = up_w - dn_w;
        over   = diff_w > XW'({RW{1'b1}});
        if (ovr_in || (over && !under)) mag_nx = '1;
        else if (under)                 mag_nx = '0;
        else                            mag_nx = diff_w[RW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag <= '0;
            neg <= 1'b0;
            ovr <= 1'b0;
        end else if (load) begin
            mag <= mag_nx;
            neg <= neg_in;
            ovr <= ovr_in;
        end
    end

    // R9: outputs move only on a load
    a_r9_hold_between_loads: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(mag) && $stable(neg) && $stable(ovr)));

    // R8: an overrange result is full scale
    a_r8_ovr_full_scale: assert property (@(posedge clk) disable iff (rst)
        ovr |-> (&mag));
endmodule

// File: rtl/islope_seq.sv
`timescale 1ns/1ps
module islope_seq
    import islope_pkg::*;
#(
    parameter int AZ_CYCLES   = 16384,
    parameter int INT_CYCLES  = 16384,
    parameter int FAST_BITS   = 9,
    parameter int SLOW_BITS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cont_mode,
    input  logic                           start,
    input  logic                           cmp_pos,
    output logic                           busy,
    output logic                           sel_autozero,
    output logic                           sel_integrate,
    output logic                           sel_ref_fast,
    output logic                           sel_ref_slow,
    output logic                           ref_negative,
    output logic [FAST_BITS+SLOW_BITS-1:0] result,
    output logic                           result_neg,
    output logic                           overrange
);
    localparam int SLOW_W  = SLOW_BITS + 2;
    localparam int LOG_AZ  = $clog2(AZ_CYCLES);
    localparam int LOG_INT = $clog2(INT_CYCLES);
    localparam int M1      = (LOG_AZ > LOG_INT) ? LOG_AZ : LOG_INT;
    localparam int M2      = (FAST_BITS > SLOW_W) ? FAST_BITS : SLOW_W;
    localparam int CNT_W   = ((M1 > M2) ? M1 : M2) + 1;
    localparam logic [CNT_W-1:0] AZ_LAST   = CNT_W'(AZ_CYCLES - 1);
    localparam logic [CNT_W-1:0] INT_LAST  = CNT_W'(INT_CYCLES - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'((2 ** FAST_BITS) - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'((2 ** SLOW_W) - 1);

    phase_t             phase, phase_nx;
    logic [CNT_W-1:0]   cnt, cnt_nx;
    logic               pos_q;
    logic [FAST_BITS:0] fast_q;
    logic               cmp_s;
    logic               take_pol, fast_end, load, ovr_hit;
    logic [SLOW_W:0]    slow_n;

    islope_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cmp_pos),
        .dout (cmp_s)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            pos_q  <= 1'b0;
            fast_q <= '0;
        end else begin
            phase <= phase_nx;
            cnt   <= cnt_nx;
            if (take_pol) pos_q  <= cmp_s;
            if (fast_end) fast_q <= (FAST_BITS+1)'(cnt) + (FAST_BITS+1)'(1);
        end
    end

    // next phase
    always_comb begin
        phase_nx = phase;
        cnt_nx   = cnt + CNT_W'(1);
        take_pol = 1'b0;
        fast_end = 1'b0;
        load     = 1'b0;
        ovr_hit  = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                cnt_nx = '0;
                if (cont_mode || start) phase_nx = PH_AZ;
            end
            PH_AZ: begin
                if (cnt == AZ_LAST) begin
                    phase_nx = PH_INTEG;
                    cnt_nx   = '0;
                end
            end
            PH_INTEG: begin
                if (cnt == INT_LAST) begin
                    phase_nx = PH_FAST;
                    cnt_nx   = '0;
                    take_pol = 1'b1;
                end
            end
            PH_FAST: begin
                if (cmp_s != pos_q) begin
                    phase_nx = PH_SLOW;
                    cnt_nx   = '0;
                    fast_end = 1'b1;
                end else if (cnt == FAST_LAST) begin
                    phase_nx = PH_IDLE;
                    cnt_nx   = '0;
                    load     = 1'b1;
                    ovr_hit  = 1'b1;
                end
            end
            PH_SLOW: begin
                if (cmp_s == pos_q || cnt == SLOW_LAST) begin
                    phase_nx = PH_IDLE;
                    cnt_nx   = '0;
                    load     = 1'b1;
                end
            end
            default: begin
                phase_nx = PH_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy          = (phase != PH_IDLE);
        sel_autozero  = (phase == PH_AZ);
        sel_integrate = (phase == PH_INTEG);
        sel_ref_fast  = (phase == PH_FAST);
        sel_ref_slow  = (phase == PH_SLOW);
        ref_negative  = ((phase == PH_FAST) && pos_q) || ((phase == PH_SLOW) && !pos_q);
    end

    assign slow_n = (SLOW_W+1)'(cnt) + (SLOW_W+1)'(1);

    islope_result #(
        .FAST_BITS (FAST_BITS),
        .SLOW_BITS (SLOW_BITS),
        .SLOW_W    (SLOW_W)
    ) u_result (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .ovr_in (ovr_hit),
        .neg_in (!pos_q),
        .fast_n (fast_q),
        .slow_n (slow_n),
        .mag    (result),
        .neg    (result_neg),
        .ovr    (overrange)
    );

    // R3: one switch group at a time
    a_r3_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_autozero, sel_integrate, sel_ref_fast, sel_ref_slow}));

    // R3: idle means all switches open
    a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(sel_autozero || sel_integrate || sel_ref_fast || sel_ref_slow));

    // R2: start taken while idle
    a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && sel_autozero));

    // R10: continuous mode restarts from idle
    a_r10_cont_restart: assert property (@(posedge clk) disable iff (rst)
        (!busy && cont_mode) |=> busy);

    // R4: reference sign flips entering the slow slope
    a_r4_ref_flip: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_ref_slow) |-> (ref_negative != $past(ref_negative)));
endmodule

// File: tb/islope_seq_bench.sv
`timescale 1ns/1ps
module islope_seq_bench;
    localparam int AZ  = 4;
    localparam int INT = 8;
    localparam int FB  = 9;
    localparam int SB  = 6;
    localparam int RW  = FB + SB;

    typedef struct {
        int mag;
        bit neg;
        bit ovr;
        int f;
        int s;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst, cont_mode, start, cmp_pos;
    logic          busy, sel_autozero, sel_integrate, sel_ref_fast, sel_ref_slow;
    logic          ref_negative, result_neg, overrange;
    logic [RW-1:0] result;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sbq[$];
    int   v = 0;
    int   cur_q = 0;
    bit   applied = 0;

    always #10 clk = ~clk;

    islope_seq #(
        .AZ_CYCLES(AZ), .INT_CYCLES(INT), .FAST_BITS(FB), .SLOW_BITS(SB), .SYNC_STAGES(2)
    ) u_islope_seq (
        .clk(clk), .rst(rst), .cont_mode(cont_mode), .start(start), .cmp_pos(cmp_pos),
        .busy(busy), .sel_autozero(sel_autozero), .sel_integrate(sel_integrate),
        .sel_ref_fast(sel_ref_fast), .sel_ref_slow(sel_ref_slow),
        .ref_negative(ref_negative), .result(result), .result_neg(result_neg),
        .overrange(overrange)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic exp_t predict(input int q);
        exp_t e;
        int a, c;
        e.neg = (q <= 0);
        if (q > 0) begin
            c   = (q + 63) / 64;
            e.f = c + 2;
            e.s = 64 * e.f - q + 3;
        end else begin
            a   = -q;
            c   = a / 64 + 1;
            e.f = c + 2;
            e.s = 64 * e.f - a + 2;
        end
        if (e.f > 512) begin
            e.ovr = 1; e.f = 512; e.s = 0; e.mag = 32767;
        end else begin
            e.ovr = 0;
            e.mag = 64 * e.f - e.s;
            if (e.mag < 0) e.mag = 0;
        end
        return e;
    endfunction

    // integrator model, updated away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            v = 0;
            cmp_pos <= 1'b0;
        end else begin
            if (sel_autozero) begin v = 0; applied = 0; end
            if (sel_integrate && !applied) begin v += cur_q; applied = 1; end
            if (sel_ref_fast) v += ref_negative ? -64 : 64;
            if (sel_ref_slow) v += ref_negative ? -1 : 1;
            cmp_pos <= (v > 0);
        end
    end

    // monitor / scoreboard
    bit            pb = 0;
    int            n_az, n_int, n_f, n_s;
    bit            sel_bad, ref_bad, hold_bad;
    logic [RW-1:0] held;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy && !pb) begin
                n_az = 0; n_int = 0; n_f = 0; n_s = 0;
                sel_bad = 0; ref_bad = 0; hold_bad = 0;
                held = result;
            end
            if (busy) begin
                if ($countones({sel_autozero, sel_integrate, sel_ref_fast, sel_ref_slow}) > 1) sel_bad = 1;
                if (sel_autozero)  n_az++;
                if (sel_integrate) n_int++;
                if (sel_ref_fast)  n_f++;
                if (sel_ref_slow)  n_s++;
                if (sbq.size() > 0) begin
                    if (sel_ref_fast && ref_negative != !sbq[0].neg) ref_bad = 1;
                    if (sel_ref_slow && ref_negative != sbq[0].neg)  ref_bad = 1;
                end
                if (result != held) hold_bad = 1;
            end else if (sel_autozero || sel_integrate || sel_ref_fast || sel_ref_slow) begin
                chk(0, "R3 select while idle", 1, 0);
            end
            if (!busy && pb) begin
                if (sbq.size() == 0) begin
                    chk(0, "R11 unexpected conversion", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(n_az == AZ,        "R2 autozero length", n_az, AZ);
                    chk(n_int == INT,      "R2 integrate length", n_int, INT);
                    chk(!sel_bad,          "R3 one select", sel_bad, 0);
                    chk(!ref_bad,          "R4 reference sign", ref_bad, 0);
                    chk(n_f == e.f,        "R5 fast cycles", n_f, e.f);
                    chk(n_s == e.s,        "R6 slow cycles", n_s, e.s);
                    chk(int'(result) == e.mag, "R7 magnitude", int'(result), e.mag);
                    chk(result_neg == e.neg, "R7 sign", result_neg, e.neg);
                    chk(overrange == e.ovr,  "R8 overrange flag", overrange, e.ovr);
                    chk(!hold_bad,         "R9 result held while busy", hold_bad, 0);
                end
            end
            pb = busy;
        end
    end

    task automatic run_conv(input int q);
        cur_q = q;
        sbq.push_back(predict(q));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && sel_autozero, "R2 start enters autozero", busy, 1);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; cont_mode = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy && !sel_autozero && !sel_integrate && !sel_ref_fast && !sel_ref_slow,
            "R1 selects in reset", busy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy, "R1 busy after reset", busy, 0);
        chk(!ref_negative, "R1 ref sign after reset", ref_negative, 0);
        chk(result == '0, "R1 result after reset", int'(result), 0);
        chk(!result_neg && !overrange, "R1 flags after reset", overrange, 0);

        run_conv(1000);     // R7 positive
        run_conv(-1000);    // R7 negative
        run_conv(6400);     // R5 exact multiple of the fast step
        run_conv(0);        // R7 clamp, zero reads negative
        run_conv(1);        // R7 clamp positive
        run_conv(5);
        run_conv(-1);
        run_conv(32640);    // R8 largest positive in range
        run_conv(32641);    // R8 positive overrange
        run_conv(-32639);   // R8 largest negative in range
        run_conv(-32640);   // R8 negative overrange

        // R11: start pulse while busy
        cur_q = 2000;
        sbq.push_back(predict(2000));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        begin
            bit stayed = 1;
            for (int i = 0; i < 20; i++) begin
                if (busy) stayed = 0;
                @(negedge clk);
            end
            chk(stayed, "R11 start while busy ignored", !stayed, 0);
        end

        // R10: continuous mode
        cur_q = -777;
        for (int i = 0; i < 3; i++) sbq.push_back(predict(-777));
        cont_mode = 1'b1;
        for (int i = 0; i < 3; i++) begin
            while (!busy) @(negedge clk);
            while (busy) @(negedge clk);
            if (i < 2) begin
                @(negedge clk);
                chk(busy, "R10 one idle cycle between conversions", busy, 1);
            end else begin
                cont_mode = 1'b0;
            end
        end
        begin
            bit quiet = 1;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (busy) quiet = 0;
            end
            chk(quiet, "R10 stop after continuous mode cleared", !quiet, 0);
        end
        chk(sbq.size() == 0, "R7 all results seen", sbq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R2 run did not complete actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule